// File: doc/BRIEF.md
# UART Interrupt Pin Generator

This block drives the active-low interrupt output of one UART channel. Each cycle it looks at the transmitter and receiver state: the FIFO fill levels, the programmed trigger levels, whether the transmit holding register holds a byte, and whether the transmit shift register is still sending. From these it decides whether a transmit or a receive service request is pending. Each request has its own enable bit, and the pin goes low when at least one enabled request is present.

Two mode bits change how the requests are worked out. The FIFO-enable bit chooses between single-byte holding-register operation and trigger-level operation. In the RS-485 direction mode, the transmit request is held back until the line driver can be turned round. With the FIFO off, that means both the holding register and the shift register are empty. With the FIFO on, it means the FIFO is below its trigger, or the whole transmitter has drained.

The output comes from a flop so that it cannot glitch. It follows its inputs one clock later. Interrupt priority, identification registers and the FIFOs themselves sit outside this block.

Top module: `uart_irq_pin`

## Requirements
- R1: `irqN` is a registered output. After any input change it takes its new value at the next rising clock edge, and not before. It is low exactly when an enabled transmit or receive request was present at that edge.
- R2: With `fifoEn`=0 and `rs485En`=0, the transmit request is present exactly when `thrFull`=0. In this mode `tsrBusy` and the FIFO levels have no effect.
- R3: With `fifoEn`=0 and `rs485En`=1, the transmit request is present only when `thrFull`=0 and `tsrBusy`=0.
- R4: With `fifoEn`=1 and `rs485En`=0, the transmit request is present when `txLevel` < `txTrigger` or when `txLevel`=0. It is absent when `txLevel` ≥ `txTrigger` and `txLevel` ≠ 0, whatever the value of `tsrBusy`.
- R5: With `fifoEn`=1 and `rs485En`=1, the transmit request is present when `txLevel` < `txTrigger`, or when `txLevel`=0 and `tsrBusy`=0. It is absent otherwise.
- R6: With `fifoEn`=0, the receive request is present exactly when `rxLevel` ≠ 0. In this mode `rxTrigger` has no effect.
- R7: With `fifoEn`=1, the receive request is present exactly when `rxLevel` ≠ 0 and `rxLevel` ≥ `rxTrigger`.
- R8: `rstN`=0 forces `irqN` high at once, without waiting for a clock edge. `irqN` stays high until the first rising edge after `rstN` returns to 1.
- R9: `txIrqEn`=0 masks the transmit request, and `rxIrqEn`=0 masks the receive request. The pin is low if either unmasked request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoEn | input | 1 | 1 selects trigger-level FIFO operation |
| rs485En | input | 1 | 1 selects RS-485 direction-turnaround transmit behaviour |
| txIrqEn | input | 1 | Enable for the transmit request |
| rxIrqEn | input | 1 | Enable for the receive request |
| txLevel | input | LEVEL_W | Bytes currently in the transmit FIFO |
| txTrigger | input | LEVEL_W | Transmit trigger level |
| rxLevel | input | LEVEL_W | Bytes currently in the receive FIFO |
| rxTrigger | input | LEVEL_W | Receive trigger level |
| thrFull | input | 1 | Transmit holding register holds a byte |
| tsrBusy | input | 1 | Transmit shift register is still sending |
| irqN | output | 1 | Interrupt pin, active low |

## Verification
All four combinations of the mode bits are driven. For each one, the bench toggles the holding-register and shift-register flags independently, which shows whether the shift-register state is being used as it should be. FIFO levels are placed just below the trigger, exactly at it and above it, and also at zero with a zero trigger. These placements locate each comparison edge and expose any difference between the plain and RS-485 empty conditions. Receive levels are tried against a large trigger with the FIFO off, to show that the trigger is ignored in that mode. Finally the enable bits are masked one at a time while both requests are present, and a behavioural model is compared with the pin on every clock.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Operating mode formed from {fifoEn, rs485En}.
  typedef enum logic [1:0] {
    MODE_HOLD     = 2'b00,
    MODE_HOLD_485 = 2'b01,
    MODE_FIFO     = 2'b10,
    MODE_FIFO_485 = 2'b11
  } txMode_e;

  // Level comparisons made by the datapath, consumed by the control.
  typedef struct packed {
    logic txBelow;     // txLevel < txTrigger
    logic txEmpty;     // txLevel == 0
    logic rxNonEmpty;  // rxLevel != 0
    logic rxAtTrig;    // rxLevel >= rxTrigger
  } cmpFlags_t;

  // Request strobes sent from the control back to the datapath.
  typedef struct packed {
    logic txReq;
    logic rxReq;
  } irqStrobes_t;

endpackage

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int LEVEL_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] txLevel,
  input  logic [LEVEL_W-1:0] txTrigger,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic [LEVEL_W-1:0] rxTrigger,
  output cmpFlags_t          flags,
  input  irqStrobes_t        strobes,
  output logic               irqN
);

  // Level comparators
  always_comb begin
    flags.txBelow    = (txLevel < txTrigger);
    flags.txEmpty    = (txLevel == '0);
    flags.rxNonEmpty = (rxLevel != '0);
    flags.rxAtTrig   = (rxLevel >= rxTrigger);
  end

  // Glitch-free output flop, reset to deasserted
  logic anyReq;
  assign anyReq = strobes.txReq | strobes.rxReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqN <= 1'b1;
    else       irqN <= ~anyReq;
  end

  AST_PIN_ASSERTS: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |=> !irqN); // R1
  AST_PIN_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    !anyReq |=> irqN); // R1

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fifoEn,
  input  logic        rs485En,
  input  logic        txIrqEn,
  input  logic        rxIrqEn,
  input  logic        thrFull,
  input  logic        tsrBusy,
  input  cmpFlags_t   flags,
  output irqStrobes_t strobes
);

  txMode_e mode;
  logic    txCond;
  logic    rxCond;

  assign mode = txMode_e'({fifoEn, rs485En});

  // Transmit request per mode
  always_comb begin
    unique case (mode)
      MODE_HOLD:     txCond = ~thrFull;
      MODE_HOLD_485: txCond = ~thrFull & ~tsrBusy;
      MODE_FIFO:     txCond = flags.txBelow | flags.txEmpty;
      MODE_FIFO_485: txCond = flags.txBelow | (flags.txEmpty & ~tsrBusy);
      default:       txCond = 1'b0;
    endcase
  end

  // Receive request: any byte without FIFO, trigger reached with FIFO
  always_comb begin
    if (fifoEn) rxCond = flags.rxNonEmpty & flags.rxAtTrig;
    else        rxCond = flags.rxNonEmpty;
  end

  assign strobes.txReq = txCond & txIrqEn;
  assign strobes.rxReq = rxCond & rxIrqEn;

  AST_THR_FULL_BLOCKS_TX: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && thrFull) |-> !strobes.txReq); // R2
  AST_SHIFT_BUSY_HOLDS_TX: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && rs485En && tsrBusy) |-> !strobes.txReq); // R3
  AST_RX_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !flags.rxNonEmpty |-> !strobes.rxReq); // R6
  AST_TX_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !txIrqEn |-> !strobes.txReq); // R9
  AST_RX_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !rxIrqEn |-> !strobes.rxReq); // R9

endmodule

// File: rtl/uart_irq_pin.sv
module uart_irq_pin
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fifoEn,
  input  logic               rs485En,
  input  logic               txIrqEn,
  input  logic               rxIrqEn,
  input  logic [LEVEL_W-1:0] txLevel,
  input  logic [LEVEL_W-1:0] txTrigger,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic [LEVEL_W-1:0] rxTrigger,
  input  logic               thrFull,
  input  logic               tsrBusy,
  output logic               irqN
);

  cmpFlags_t   flags;
  irqStrobes_t strobes;

  uart_irq_dp #(.LEVEL_W(LEVEL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .txLevel   (txLevel),
    .txTrigger (txTrigger),
    .rxLevel   (rxLevel),
    .rxTrigger (rxTrigger),
    .flags     (flags),
    .strobes   (strobes),
    .irqN      (irqN)
  );

  uart_irq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .fifoEn  (fifoEn),
    .rs485En (rs485En),
    .txIrqEn (txIrqEn),
    .rxIrqEn (rxIrqEn),
    .thrFull (thrFull),
    .tsrBusy (tsrBusy),
    .flags   (flags),
    .strobes (strobes)
  );

endmodule

// File: tb/tb_uart_irq_pin.sv
module tb_uart_irq_pin;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEn = 0, rs485En = 0, txIrqEn = 0, rxIrqEn = 0;
  logic [LW-1:0] txLevel = '0, txTrigger = '0, rxLevel = '0, rxTrigger = '0;
  logic thrFull = 0, tsrBusy = 0;
  logic irqN;

  int nTests = 0;
  int nFails = 0;
  bit modelIrqN;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_pin dut (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .rs485En(rs485En),
    .txIrqEn(txIrqEn), .rxIrqEn(rxIrqEn), .txLevel(txLevel),
    .txTrigger(txTrigger), .rxLevel(rxLevel), .rxTrigger(rxTrigger),
    .thrFull(thrFull), .tsrBusy(tsrBusy), .irqN(irqN)
  );

  // Behavioural reference, written from the requirements
  function automatic bit refTx();
    int lvl = int'(txLevel);
    int trg = int'(txTrigger);
    if (!fifoEn) return rs485En ? (!thrFull && !tsrBusy) : !thrFull;
    if (rs485En) return (lvl < trg) || (lvl == 0 && !tsrBusy);
    return (lvl < trg) || (lvl == 0);
  endfunction

  function automatic bit refRx();
    int lvl = int'(rxLevel);
    if (!fifoEn) return lvl != 0;
    return (lvl != 0) && (lvl >= int'(rxTrigger));
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) modelIrqN <= 1'b1;
    else       modelIrqN <= !((refTx() && txIrqEn) || (refRx() && rxIrqEn));
  end

  // Every-clock comparison with the model
  always @(negedge clk) begin
    nTests++;
    if (irqN !== modelIrqN) begin
      nFails++;
      $display("FAIL model R1: irqN=%0b expected %0b at %0t", irqN, modelIrqN, $time);
    end
  end

  task automatic chk(input string tag, input bit expN);
    nTests++;
    if (irqN !== expN) begin
      nFails++;
      $display("FAIL %s: irqN=%0b expected %0b at %0t", tag, irqN, expN, $time);
    end
  endtask

  // Inputs take effect at one edge; the check sits at the following negedge
  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nFails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    // R8 reset: requests present yet pin held high
    txIrqEn = 1; rxIrqEn = 1; thrFull = 0; rxLevel = 3;
    repeat (3) @(negedge clk);
    chk("R8 in reset", 1'b1);
    #2 rstN = 1'b1;
    #1 chk("R8 before first edge", 1'b1);
    settle(); chk("R8 after release", 1'b0);
    #1 rstN = 1'b0;
    #1 chk("R8 async assert", 1'b1);
    @(negedge clk); rstN = 1'b1; rxLevel = 0; rxIrqEn = 0;

    // R2 holding register, plain mode
    fifoEn = 0; rs485En = 0; thrFull = 1; settle(); chk("R2 thr full", 1'b1);
    thrFull = 0;
    #1 chk("R1 no change before edge", 1'b1);
    settle(); chk("R2 thr empty", 1'b0);
    tsrBusy = 1; txLevel = 50; txTrigger = 10; settle(); chk("R2 shift/level ignored", 1'b0);

    // R3 RS-485 without FIFO
    rs485En = 1; settle(); chk("R3 shift busy", 1'b1);
    tsrBusy = 0; settle(); chk("R3 all empty", 1'b0);
    thrFull = 1; settle(); chk("R3 thr full", 1'b1);

    // R4 FIFO, plain
    fifoEn = 1; rs485En = 0; thrFull = 0; tsrBusy = 1; txTrigger = 16;
    txLevel = 8;  settle(); chk("R4 below trigger", 1'b0);
    txLevel = 16; settle(); chk("R4 at trigger", 1'b1);
    txLevel = 40; settle(); chk("R4 above trigger", 1'b1);
    txLevel = 0;  settle(); chk("R4 empty", 1'b0);
    txTrigger = 0; settle(); chk("R4 trig0 empty", 1'b0);
    txLevel = 5;  settle(); chk("R4 trig0 nonempty", 1'b1);

    // R5 FIFO, RS-485
    rs485En = 1; txTrigger = 16; txLevel = 8; tsrBusy = 1;
    settle(); chk("R5 below trigger busy", 1'b0);
    txTrigger = 0; txLevel = 0; settle(); chk("R5 empty fifo shift busy", 1'b1);
    tsrBusy = 0; settle(); chk("R5 fully empty", 1'b0);
    txLevel = 20; settle(); chk("R5 above trigger idle", 1'b1);

    // R6 receive, no FIFO
    txIrqEn = 0; rxIrqEn = 1; fifoEn = 0; rxTrigger = 60;
    rxLevel = 0; settle(); chk("R6 no data", 1'b1);
    rxLevel = 1; settle(); chk("R6 one byte, trigger ignored", 1'b0);

    // R7 receive, FIFO
    fifoEn = 1; rxTrigger = 32;
    rxLevel = 31; settle(); chk("R7 below trigger", 1'b1);
    rxLevel = 32; settle(); chk("R7 at trigger", 1'b0);
    rxLevel = 64; settle(); chk("R7 full", 1'b0);
    rxTrigger = 0; rxLevel = 0; settle(); chk("R7 trig0 empty", 1'b1);

    // R9 masking with both requests present
    fifoEn = 0; rs485En = 0; thrFull = 0; rxLevel = 2;
    txIrqEn = 0; rxIrqEn = 0; settle(); chk("R9 both masked", 1'b1);
    txIrqEn = 1; settle(); chk("R9 tx only", 1'b0);
    txIrqEn = 0; rxIrqEn = 1; settle(); chk("R9 rx only", 1'b0);
    rxLevel = 0; settle(); chk("R9 rx enabled no data", 1'b1);

    settle();
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule